// File: doc/BRIEF.md
# Clock Divider Parameter Solver

This block turns a requested output clock period into the settings of a frequency synthesizer whose output frequency is 2·Fref·FB/(REF·POST). Given the reference clock period, the reference divider and the target period, it forms a scaled ratio with a sequential restoring divider. From that ratio it picks a post-divider index, looks up the real post-divide factor and derives the feedback divider. Requests whose ratio lies outside the usable window are flagged as errors.

A second mode serves the memory clock path. In that mode the ratio is built with a selectable feedback multiplier of 2 or 4 instead of the fixed factor of 4. A caller pulses `start_i` while the block is idle. The inputs are captured on that edge. The results appear together with a one-cycle `done_o` pulse and stay on the outputs until the next result is produced.

Top module: `clk_div_solver`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `ratio_o`, `post_idx_o`, `post_div_o` and `fb_div_o` are all zero.
- R2: With `mem_clk_i`=0, `ratio_o` equals floor(ref_period × ref_div × 4 / target_period).
- R3: With `mem_clk_i`=1, `ratio_o` equals floor(ref_period × ref_div × 8 / (target_period × M)), where M is 4 when `fb_mult4_i`=1 and 2 otherwise.
- R4: `err_o` is 1 when the ratio is below 128 or above 2040. In that case `post_idx_o`, `post_div_o` and `fb_div_o` are zero.
- R5: `post_idx_o` is the number of the conditions ratio<1024, ratio<512 and ratio<256 that hold, so it lies in 0..3.
- R6: `post_div_o` is the binary value of the real post-divide factor. Index 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8, and the table also maps index 4 to 3.
- R7: `fb_div_o` equals floor(ratio × post_div / 8). For every accepted request it lies in 128..255.
- R8: `done_o` is a single-cycle pulse. It goes high DW+1 clock cycles after the edge that accepts `start_i`, and `busy_o` is low while it is high. The result outputs do not change in any cycle where `done_o` is low.
- R9: A `start_i` pulse while `busy_o` is high is ignored. It produces no extra `done_o` and does not alter the running result.
- R10: A target period of zero is flagged through `err_o`, and `ratio_o` then reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, accepted only when idle |
| ref_period_i | input | PW | Reference clock period |
| ref_div_i | input | RW | Reference divider |
| target_period_i | input | PW | Requested output period |
| mem_clk_i | input | 1 | 1: memory-clock ratio form with selectable multiplier |
| fb_mult4_i | input | 1 | Memory mode feedback multiplier: 1 selects 4, 0 selects 2 |
| busy_o | output | 1 | Solve in progress |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Request out of range or zero target |
| ratio_o | output | DW | Scaled ratio q |
| post_idx_o | output | 3 | Post-divider index |
| post_div_o | output | 4 | Real post-divide factor |
| fb_div_o | output | 8 | Feedback divider |

## Verification
A wrong remainder or quotient bit in the divider shows up as a wrong `ratio_o` on the `done_o` pulse. It usually also moves the post index or feedback value, or flips `err_o`, and it never shows earlier than DW+1 cycles after acceptance. An off-by-one in the step counter shifts the `done_o` cycle, which the latency check catches on the first request. Requests are placed on both sides of every threshold and both window edges, so a wrong comparison corrupts the index or error flag of the very next result.

// File: rtl/clk_div_solver_pkg.sv
package clk_div_solver_pkg;

  localparam int unsigned POST_IDX_W = 3;
  localparam int unsigned POST_VAL_W = 4;
  localparam int unsigned FB_W       = 8;
  localparam int unsigned Q_MIN      = 16 * 8;
  localparam int unsigned Q_MAX      = 255 * 8;
  localparam int unsigned N_THRESH   = 3;

  typedef enum logic {
    ST_IDLE,
    ST_RUN
  } solver_state_e;

  // threshold k: ratio below it bumps the post index
  function automatic int unsigned thresh(input int unsigned k);
    return (128 * 8) >> k;
  endfunction

  // irregular index -> real divide factor
  function automatic logic [POST_VAL_W-1:0] post_real(input logic [POST_IDX_W-1:0] idx);
    case (idx)
      3'd0:    post_real = 4'd1;
      3'd1:    post_real = 4'd2;
      3'd2:    post_real = 4'd4;
      3'd3:    post_real = 4'd8;
      3'd4:    post_real = 4'd3;
      default: post_real = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/cds_operand_prep.sv
module cds_operand_prep #(
  parameter int unsigned PW = 16,
  parameter int unsigned RW = 8,
  parameter int unsigned DW = 32
) (
  input  logic [PW-1:0] ref_period_i,
  input  logic [RW-1:0] ref_div_i,
  input  logic [PW-1:0] target_period_i,
  input  logic          mem_clk_i,
  input  logic          fb_mult4_i,
  output logic [DW-1:0] dividend_o,
  output logic [DW-1:0] divisor_o,
  output logic          div_zero_o
);
  localparam int unsigned PROD_W = PW + RW;

  logic [PROD_W-1:0] prod;
  logic [DW-1:0]     prod_ext;
  logic [DW-1:0]     tgt_ext;

  assign prod     = PROD_W'(ref_period_i) * PROD_W'(ref_div_i);
  assign prod_ext = DW'(prod);
  assign tgt_ext  = DW'(target_period_i);

  always_comb begin
    if (mem_clk_i) begin
      dividend_o = prod_ext << 3;
      divisor_o  = fb_mult4_i ? (tgt_ext << 2) : (tgt_ext << 1);
    end else begin
      dividend_o = prod_ext << 2;
      divisor_o  = tgt_ext;
    end
  end

  assign div_zero_o = (target_period_i == '0);

endmodule

// File: rtl/cds_restoring_div.sv
module cds_restoring_div #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [DW-1:0] divisor_i,
  output logic [DW-1:0] quotient_o,
  output logic          fin_o
);
  localparam int unsigned CW = $clog2(DW + 1);

  logic [DW-1:0] rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, fin_q;
  logic [DW:0]   shifted, diff;

  assign shifted = {rem_q, quo_q[DW-1]};
  assign diff    = shifted - {1'b0, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else if (start_i) begin
      rem_q <= '0;
      quo_q <= dividend_i;
      dvs_q <= divisor_i;
      cnt_q <= CW'(DW);
      run_q <= 1'b1;
      fin_q <= 1'b0;
    end else if (run_q) begin
      // one quotient bit per cycle, restore on borrow
      if (!diff[DW]) begin
        rem_q <= diff[DW-1:0];
        quo_q <= {quo_q[DW-2:0], 1'b1};
      end else begin
        rem_q <= shifted[DW-1:0];
        quo_q <= {quo_q[DW-2:0], 1'b0};
      end
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        run_q <= 1'b0;
        fin_q <= 1'b1;
      end
    end else begin
      fin_q <= 1'b0;
    end
  end

  assign quotient_o = quo_q;
  assign fin_o      = fin_q;

endmodule

// File: rtl/cds_post_select.sv
module cds_post_select
  import clk_div_solver_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0]         ratio_i,
  input  logic                  div_zero_i,
  output logic                  err_o,
  output logic [POST_IDX_W-1:0] idx_o,
  output logic [POST_VAL_W-1:0] real_o,
  output logic [FB_W-1:0]       fb_o
);
  logic [N_THRESH-1:0]   below;
  logic [POST_IDX_W-1:0] idx_raw;
  logic [POST_VAL_W-1:0] real_raw;
  logic [15:0]           fb_prod;

  for (genvar k = 0; k < N_THRESH; k++) begin : g_thr
    assign below[k] = (ratio_i < DW'(thresh(k)));
  end

  always_comb begin
    idx_raw = '0;
    for (int k = 0; k < N_THRESH; k++) begin
      if (below[k]) idx_raw = idx_raw + POST_IDX_W'(1);
    end
  end

  assign real_raw = post_real(idx_raw);
  assign fb_prod  = 16'(ratio_i[11:0]) * 16'(real_raw);

  assign err_o  = div_zero_i || (ratio_i < DW'(Q_MIN)) || (ratio_i > DW'(Q_MAX));
  assign idx_o  = err_o ? '0 : idx_raw;
  assign real_o = err_o ? '0 : real_raw;
  assign fb_o   = err_o ? '0 : fb_prod[10:3];

endmodule

// File: rtl/clk_div_solver.sv
module clk_div_solver
  import clk_div_solver_pkg::*;
#(
  parameter int unsigned PW = 16,
  parameter int unsigned RW = 8,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [PW-1:0] ref_period_i,
  input  logic [RW-1:0] ref_div_i,
  input  logic [PW-1:0] target_period_i,
  input  logic          mem_clk_i,
  input  logic          fb_mult4_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] ratio_o,
  output logic [2:0]    post_idx_o,
  output logic [3:0]    post_div_o,
  output logic [7:0]    fb_div_o
);
  solver_state_e state_q;
  logic          accept;
  logic [DW-1:0] dividend, divisor, quotient, ratio_eff;
  logic          div_zero, div_zero_q, div_fin;
  logic          sel_err;
  logic [POST_IDX_W-1:0] sel_idx;
  logic [POST_VAL_W-1:0] sel_real;
  logic [FB_W-1:0]       sel_fb;

  assign accept = start_i && (state_q == ST_IDLE);

  cds_operand_prep #(.PW(PW), .RW(RW), .DW(DW)) u_prep (
    .ref_period_i    (ref_period_i),
    .ref_div_i       (ref_div_i),
    .target_period_i (target_period_i),
    .mem_clk_i       (mem_clk_i),
    .fb_mult4_i      (fb_mult4_i),
    .dividend_o      (dividend),
    .divisor_o       (divisor),
    .div_zero_o      (div_zero)
  );

  cds_restoring_div #(.DW(DW)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .dividend_i (dividend),
    .divisor_i  (divisor),
    .quotient_o (quotient),
    .fin_o      (div_fin)
  );

  assign ratio_eff = div_zero_q ? '1 : quotient;

  cds_post_select #(.DW(DW)) u_sel (
    .ratio_i    (ratio_eff),
    .div_zero_i (div_zero_q),
    .err_o      (sel_err),
    .idx_o      (sel_idx),
    .real_o     (sel_real),
    .fb_o       (sel_fb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      div_zero_q <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      ratio_o    <= '0;
      post_idx_o <= '0;
      post_div_o <= '0;
      fb_div_o   <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q    <= ST_RUN;
          div_zero_q <= div_zero;
        end
        ST_RUN: if (div_fin) begin
          state_q    <= ST_IDLE;
          done_o     <= 1'b1;
          err_o      <= sel_err;
          ratio_o    <= ratio_eff;
          post_idx_o <= sel_idx;
          post_div_o <= sel_real;
          fb_div_o   <= sel_fb;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/clk_div_solver_chk.sv
module clk_div_solver_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic [DW-1:0] ratio_o,
  input logic [2:0]    post_idx_o,
  input logic [3:0]    post_div_o,
  input logic [7:0]    fb_div_o
);

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R8

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);  // R8

  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(ratio_o) && $stable(err_o) && $stable(fb_div_o)
                 && $stable(post_div_o) && $stable(post_idx_o)));  // R8

  AST_ERR_ZERO_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (post_idx_o == 3'd0 && post_div_o == 4'd0 && fb_div_o == 8'd0));  // R4

  AST_FB_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (fb_div_o >= 8'd128));  // R7

  AST_POST_POW2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> ($countones(post_div_o) == 1 && post_idx_o < 3'd4));  // R6

  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);  // R9

endmodule

bind clk_div_solver clk_div_solver_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .ratio_o    (ratio_o),
  .post_idx_o (post_idx_o),
  .post_div_o (post_div_o),
  .fb_div_o   (fb_div_o)
);

// File: tb/clk_div_solver_tb.sv
module clk_div_solver_tb;
  localparam int unsigned PW = 16;
  localparam int unsigned RW = 8;
  localparam int unsigned DW = 32;

  typedef struct {
    logic [DW-1:0] q;
    logic          err;
    logic [2:0]    idx;
    logic [3:0]    pdiv;
    logic [7:0]    fb;
    int unsigned   cyc;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [PW-1:0] ref_p = '0;
  logic [RW-1:0] ref_d = '0;
  logic [PW-1:0] tgt = '0;
  logic          mem = 1'b0;
  logic          m4 = 1'b0;
  logic          busy, done, err;
  logic [DW-1:0] ratio;
  logic [2:0]    pidx;
  logic [3:0]    pdiv;
  logic [7:0]    fb;

  int unsigned checks = 0;
  int unsigned fails = 0;
  int unsigned cyc = 0;
  exp_t        exp_q[$];
  logic [7:0]  last_fb;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clk_div_solver #(.PW(PW), .RW(RW), .DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .ref_period_i(ref_p), .ref_div_i(ref_d), .target_period_i(tgt),
    .mem_clk_i(mem), .fb_mult4_i(m4),
    .busy_o(busy), .done_o(done), .err_o(err), .ratio_o(ratio),
    .post_idx_o(pidx), .post_div_o(pdiv), .fb_div_o(fb)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  function automatic exp_t model(input int unsigned r, input int unsigned d, input int unsigned t,
                                 input bit mm, input bit mul4);
    exp_t e;
    longint unsigned num, den, q, rv;
    int unsigned ix;
    num = longint'(r) * longint'(d) * (mm ? 8 : 4);
    den = mm ? longint'(t) * (mul4 ? 4 : 2) : longint'(t);
    q = (den == 0) ? 64'hFFFF_FFFF : num / den;
    e.q = q[DW-1:0];
    e.err = (t == 0) || (q < 128) || (q > 2040);
    ix = 0;
    if (q < 1024) ix++;
    if (q < 512) ix++;
    if (q < 256) ix++;
    rv = (ix == 0) ? 1 : (ix == 1) ? 2 : (ix == 2) ? 4 : 8;
    e.idx  = e.err ? 3'd0 : 3'(ix);
    e.pdiv = e.err ? 4'd0 : 4'(rv);
    e.fb   = e.err ? 8'd0 : 8'((q * rv) / 8);
    return e;
  endfunction

  task automatic send(input int unsigned r, input int unsigned d, input int unsigned t,
                      input bit mm, input bit mul4, input string tag);
    exp_t e;
    while (busy) @(negedge clk);
    e = model(r, d, t, mm, mul4);
    e.tag = tag;
    ref_p = PW'(r); ref_d = RW'(d); tgt = PW'(t); mem = mm; m4 = mul4;
    start = 1'b1;
    e.cyc = cyc;
    exp_q.push_back(e);
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(ratio == e.q, {e.tag, " ratio"}, longint'(ratio), longint'(e.q));
        chk(err == e.err, {e.tag, " R4 err"}, longint'(err), longint'(e.err));
        chk(pidx == e.idx, {e.tag, " R5 post_idx"}, longint'(pidx), longint'(e.idx));
        chk(pdiv == e.pdiv, {e.tag, " R6 post_div"}, longint'(pdiv), longint'(e.pdiv));
        chk(fb == e.fb, {e.tag, " R7 fb_div"}, longint'(fb), longint'(e.fb));
        // accept edge is one after e.cyc; done visible DW+1 edges later
        chk((cyc - e.cyc) == DW + 2, "R8 latency", longint'(cyc - e.cyc), longint'(DW + 2));
        chk(!busy, "R8 busy low at done", longint'(busy), 0);
      end
    end
  end

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog R8 act=timeout exp=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err, "R1 ctrl reset", longint'({busy, done, err}), 0);
    chk(ratio == '0 && pidx == '0 && pdiv == '0 && fb == '0, "R1 data reset", longint'(fb), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // pixel mode across the post-divider bands
    send(1000, 10,  20, 0, 0, "R2");
    send(1000, 10,  40, 0, 0, "R2");
    send(1000, 10, 100, 0, 0, "R2");
    send(1000, 10, 200, 0, 0, "R2");
    send(1000, 10, 300, 0, 0, "R2");
    // threshold edges (ratio = r when d=1, t=4)
    send(1024, 1, 4, 0, 0, "R5 q1024");
    send(1023, 1, 4, 0, 0, "R5 q1023");
    send(512,  1, 4, 0, 0, "R5 q512");
    send(511,  1, 4, 0, 0, "R5 q511");
    send(256,  1, 4, 0, 0, "R5 q256");
    send(255,  1, 4, 0, 0, "R5 q255");
    // window edges
    send(128,  1, 4, 0, 0, "R4 q128");
    send(127,  1, 4, 0, 0, "R4 q127");
    send(2040, 1, 4, 0, 0, "R4 q2040");
    send(2041, 1, 4, 0, 0, "R4 q2041");
    send(1000, 10, 400, 0, 0, "R4 low");
    // memory mode, both multipliers
    send(1000, 10, 50, 1, 1, "R3 x4");
    send(1000, 10, 50, 1, 0, "R3 x2");
    send(3333, 7, 91, 1, 1, "R3 x4b");
    send(3333, 7, 91, 1, 0, "R3 x2b");
    // zero target
    send(1000, 10, 0, 0, 0, "R10 pix");
    send(1000, 10, 0, 1, 1, "R10 mem");

    for (int i = 0; i < 24; i++) begin
      int unsigned r, d, qt, t;
      r  = $urandom_range(65535, 200);
      d  = $urandom_range(255, 1);
      qt = $urandom_range(2200, 100);
      t  = (r * d * 4) / qt;
      if (t > 65535) t = 65535;
      if (t == 0) t = 1;
      send(r, d, t, i[0], i[1], "R7 rand");
    end

    // start while busy must be ignored
    send(1000, 10, 40, 0, 0, "R9 first");
    repeat (5) @(negedge clk);
    chk(busy == 1'b1, "R9 busy", longint'(busy), 1);
    ref_p = 16'd77; ref_d = 8'd3; tgt = 16'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    last_fb = fb;
    repeat (DW + 10) @(negedge clk);
    chk(exp_q.size() == 0, "R9 queue drained", longint'(exp_q.size()), 0);
    chk(fb == last_fb && fb == 8'd250, "R8 hold fb", longint'(fb), 250);
    chk(!busy && !done, "R9 no extra run", longint'({busy, done}), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule